// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block decides which power state an Ethernet transceiver occupies and drives the enables of its transmitter, energy-detect circuit, receive datapath and management interface. There are three low-power modes. A software-controlled off mode is set and cleared through a basic register bit. An energy-sleep mode is allowed by an extended register bit and applies only while auto-negotiation is on and no link or line energy is present. A chip-off mode is selected by a 4-bit strap captured during reset.

While energy-sleep is active, a link-pulse timer issues a one-cycle request at a programmable interval, so that two sleeping peers can still wake each other. The timer counts prescaled ticks. The register bits are reached through a simple parallel write strobe with a device/address select, and the addressed register can always be read while the management interface is enabled. The reset input is asserted asynchronously and released through a synchronizer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset with a strap other than 0111, `pwr_mode` is 0 (normal) and all four enables are 1. The off bit and the energy-sleep enable read 0, and the interval register reads its reset parameter `INTV_RST`.
- R2: A write to basic register 0 (`mgmt_ext`=0, `mgmt_addr`=00h) loads bit 11 of `mgmt_wdata` into the off bit, and every other bit of that write is ignored. Once the bit is 1, `pwr_mode` becomes 1 (software off) two clock edges after the write cycle. Writing the bit back to 0 returns the block to normal with the same latency.
- R3: In software off, only `mgmt_en` is 1. Reads still return the register contents: basic register 0 gives the off bit at bit 11, extended 1Ch/23h gives the enable at bit 0, and extended 1Ch/24h gives the interval.
- R4: The energy-sleep enable is bit 0 of extended register 23h in device 1Ch (`mgmt_ext`=1). `pwr_mode` becomes 2 on the edge after the enable is 1, `an_en` is 1, `link_up` is 0 and `energy_det` is 0, provided no higher mode applies.
- R5: In energy-sleep, `tx_en`, `ed_en` and `mgmt_en` are 1 and `rx_en` is 0.
- R6: Energy-sleep is left on the first edge that samples `energy_det`=1, `link_up`=1, `an_en`=0 or a cleared enable bit.
- R7: In energy-sleep, `lp_req` is a one-cycle pulse every `PRESCALE`*N cycles, where N is extended register 1Ch/24h and a value of 0 acts as 1. The first pulse comes `PRESCALE`*N cycles after entry. `lp_req` is never 1 outside energy-sleep.
- R8: A reset with `strap_mode`=0111 gives `pwr_mode`=3 (chip off). In this mode all enables are 0, `mgmt_rdata` is 0 and every register write is ignored. Only a reset with a different strap leaves the mode.
- R9: Priority is chip off, then software off, then energy-sleep, then normal.
- R10: Writes to any other device or address change none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 4 | Mode strap, captured during reset |
| an_en | input | 1 | Auto-negotiation enabled |
| link_up | input | 1 | Link established |
| energy_det | input | 1 | Line energy detected |
| mgmt_wr | input | 1 | Register write strobe |
| mgmt_ext | input | 1 | 0 = basic register space, 1 = extended space |
| mgmt_dev | input | 5 | Extended device address |
| mgmt_addr | input | 8 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data of the addressed register |
| tx_en | output | 1 | Transmitter enable |
| ed_en | output | 1 | Energy-detect circuit enable |
| rx_en | output | 1 | Receive datapath enable |
| mgmt_en | output | 1 | Management interface enable |
| pwr_mode | output | 2 | 0 normal, 1 software off, 2 energy-sleep, 3 chip off |
| lp_req | output | 1 | Link-pulse request |

## Verification
Two events can land in the same cycle: an energy-sleep exit condition and a link-pulse expiry, or a write to the off bit while energy-sleep is active. Random toggling of link and energy inputs, together with random off-bit writes, lines these up against the pulse period. A cycle model then judges each edge: it requires that the exiting cycle shows no pulse and that the higher-priority mode wins.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'd0,
    PM_SOFT_OFF = 2'd1,
    PM_SLEEP    = 2'd2,
    PM_CHIP_OFF = 2'd3
  } pwr_mode_e;

  typedef struct packed {
    logic tx;
    logic ed;
    logic rx;
    logic mgmt;
  } pwr_en_t;

  localparam logic [3:0] STRAP_CHIP_OFF = 4'b0111;
  localparam int         OFF_BIT        = 11;
  localparam logic [7:0] BASIC_CTRL     = 8'h00;
  localparam logic [4:0] EXT_DEV        = 5'h1C;
  localparam logic [7:0] EXT_SLEEP      = 8'h23;
  localparam logic [7:0] EXT_INTV       = 8'h24;

  function automatic pwr_en_t mode_enables(input pwr_mode_e m);
    pwr_en_t e;
    case (m)
      PM_NORMAL:   e = '{tx: 1'b1, ed: 1'b1, rx: 1'b1, mgmt: 1'b1};
      PM_SOFT_OFF: e = '{tx: 1'b0, ed: 1'b0, rx: 1'b0, mgmt: 1'b1};
      PM_SLEEP:    e = '{tx: 1'b1, ed: 1'b1, rx: 1'b0, mgmt: 1'b1};
      default:     e = '{tx: 1'b0, ed: 1'b0, rx: 1'b0, mgmt: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_regfile.sv
module pwr_regfile
  import pwr_pkg::*;
#(
  parameter int          INTV_W   = 16,
  parameter logic [15:0] INTV_RST = 16'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              rd_en,
  input  logic              mgmt_wr,
  input  logic              mgmt_ext,
  input  logic [4:0]        mgmt_dev,
  input  logic [7:0]        mgmt_addr,
  input  logic [15:0]       mgmt_wdata,
  output logic [15:0]       mgmt_rdata,
  output logic              off_q,
  output logic              sleep_en_q,
  output logic [INTV_W-1:0] intv_q
);
  logic              sel_basic, sel_sleep, sel_intv;
  logic              off_d, sleep_en_d;
  logic [INTV_W-1:0] intv_d;

  assign sel_basic = !mgmt_ext && (mgmt_addr == BASIC_CTRL);
  assign sel_sleep = mgmt_ext && (mgmt_dev == EXT_DEV) && (mgmt_addr == EXT_SLEEP);
  assign sel_intv  = mgmt_ext && (mgmt_dev == EXT_DEV) && (mgmt_addr == EXT_INTV);

  always_comb begin
    off_d      = off_q;
    sleep_en_d = sleep_en_q;
    intv_d     = intv_q;
    if (mgmt_wr && !lock) begin
      if (sel_basic) off_d      = mgmt_wdata[OFF_BIT];
      if (sel_sleep) sleep_en_d = mgmt_wdata[0];
      if (sel_intv)  intv_d     = mgmt_wdata[INTV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q      <= 1'b0;
      sleep_en_q <= 1'b0;
      intv_q     <= INTV_RST[INTV_W-1:0];
    end else begin
      off_q      <= off_d;
      sleep_en_q <= sleep_en_d;
      intv_q     <= intv_d;
    end
  end

  always_comb begin
    mgmt_rdata = '0;
    if (rd_en) begin
      if (sel_basic) mgmt_rdata[OFF_BIT] = off_q;
      if (sel_sleep) mgmt_rdata[0]       = sleep_en_q;
      if (sel_intv)  mgmt_rdata          = 16'(intv_q);
    end
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strap_mode,
  input  logic       off_bit,
  input  logic       sleep_en,
  input  logic       an_en,
  input  logic       link_up,
  input  logic       energy_det,
  output logic       chip_off,
  output pwr_mode_e  mode_q
);
  logic [3:0] strap_q;
  logic       sleep_ok;
  pwr_mode_e  mode_d;

  // strap is captured on every clock while the synchronized reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_mode;
  end

  assign chip_off = (strap_q == STRAP_CHIP_OFF);
  assign sleep_ok = sleep_en && an_en && !link_up && !energy_det;

  always_comb begin
    if (chip_off)      mode_d = PM_CHIP_OFF;
    else if (off_bit)  mode_d = PM_SOFT_OFF;
    else if (sleep_ok) mode_d = PM_SLEEP;
    else               mode_d = PM_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_NORMAL;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/pwr_lp_timer.sv
module pwr_lp_timer #(
  parameter int PRESCALE = 8,
  parameter int INTV_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [INTV_W-1:0] interval,
  output logic              lp_req
);
  localparam int              PRE_W    = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [INTV_W-1:0] cnt_q, cnt_d;
  logic [INTV_W-1:0] limit;
  logic              pulse_q, pulse_d;
  logic              tick, hit;

  assign tick  = active && (pre_q == PRE_LAST);
  assign limit = (interval == '0) ? INTV_W'(1) : interval;
  assign hit   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

  always_comb begin
    pre_d   = '0;
    cnt_d   = '0;
    pulse_d = 1'b0;
    if (active) begin
      pre_d   = tick ? '0 : pre_q + 1'b1;
      cnt_d   = tick ? (hit ? '0 : cnt_q + 1'b1) : cnt_q;
      pulse_d = tick && hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign lp_req = pulse_q && active;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int          PRESCALE    = 8,
  parameter int          INTV_W      = 16,
  parameter logic [15:0] INTV_RST    = 16'd4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  strap_mode,
  input  logic        an_en,
  input  logic        link_up,
  input  logic        energy_det,
  input  logic        mgmt_wr,
  input  logic        mgmt_ext,
  input  logic [4:0]  mgmt_dev,
  input  logic [7:0]  mgmt_addr,
  input  logic [15:0] mgmt_wdata,
  output logic [15:0] mgmt_rdata,
  output logic        tx_en,
  output logic        ed_en,
  output logic        rx_en,
  output logic        mgmt_en,
  output logic [1:0]  pwr_mode,
  output logic        lp_req
);
  logic              rst_s_n;
  logic              chip_off;
  logic              off_q, sleep_en_q;
  logic [INTV_W-1:0] intv_q;
  pwr_mode_e         mode_q;
  pwr_en_t           en;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  pwr_regfile #(.INTV_W(INTV_W), .INTV_RST(INTV_RST)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .lock(chip_off), .rd_en(en.mgmt),
    .mgmt_wr(mgmt_wr), .mgmt_ext(mgmt_ext), .mgmt_dev(mgmt_dev),
    .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
    .off_q(off_q), .sleep_en_q(sleep_en_q), .intv_q(intv_q)
  );

  pwr_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .strap_mode(strap_mode),
    .off_bit(off_q), .sleep_en(sleep_en_q), .an_en(an_en),
    .link_up(link_up), .energy_det(energy_det),
    .chip_off(chip_off), .mode_q(mode_q)
  );

  pwr_lp_timer #(.PRESCALE(PRESCALE), .INTV_W(INTV_W)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .active(mode_q == PM_SLEEP),
    .interval(intv_q), .lp_req(lp_req)
  );

  assign en       = mode_enables(mode_q);
  assign tx_en    = en.tx;
  assign ed_en    = en.ed;
  assign rx_en    = en.rx;
  assign mgmt_en  = en.mgmt;
  assign pwr_mode = mode_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  pwr_mode,
  input logic        tx_en,
  input logic        ed_en,
  input logic        rx_en,
  input logic        mgmt_en,
  input logic        lp_req,
  input logic        energy_det,
  input logic        link_up,
  input logic        an_en,
  input logic [15:0] mgmt_rdata
);
  assert_chip_off_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3) |-> (!tx_en && !ed_en && !rx_en && !mgmt_en && mgmt_rdata == 16'd0));

  assert_chip_off_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3) |=> (pwr_mode == 2'd3));

  assert_soft_off_mgmt_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd1) |-> (mgmt_en && !tx_en && !ed_en && !rx_en));

  assert_sleep_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2) |-> (tx_en && ed_en && !rx_en && mgmt_en));

  assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_mode == 2'd2) && (energy_det || link_up || !an_en)) |=> (pwr_mode != 2'd2));

  assert_pulse_in_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> (pwr_mode == 2'd2));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |=> !lp_req);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .tx_en(tx_en),
  .ed_en(ed_en), .rx_en(rx_en), .mgmt_en(mgmt_en), .lp_req(lp_req),
  .energy_det(energy_det), .link_up(link_up), .an_en(an_en),
  .mgmt_rdata(mgmt_rdata)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int          PRESC    = 4;
  localparam logic [15:0] INTV_DEF = 16'd5;

  logic        clk;
  logic        rst_n;
  logic [3:0]  strap_mode;
  logic        an_en, link_up, energy_det;
  logic        mgmt_wr, mgmt_ext;
  logic [4:0]  mgmt_dev;
  logic [7:0]  mgmt_addr;
  logic [15:0] mgmt_wdata, mgmt_rdata;
  logic        tx_en, ed_en, rx_en, mgmt_en, lp_req;
  logic [1:0]  pwr_mode;

  pwr_mode_ctrl #(.PRESCALE(PRESC), .INTV_W(16), .INTV_RST(INTV_DEF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .an_en(an_en),
    .link_up(link_up), .energy_det(energy_det), .mgmt_wr(mgmt_wr),
    .mgmt_ext(mgmt_ext), .mgmt_dev(mgmt_dev), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .tx_en(tx_en),
    .ed_en(ed_en), .rx_en(rx_en), .mgmt_en(mgmt_en), .pwr_mode(pwr_mode),
    .lp_req(lp_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  logic [1:0]  m_mode;
  logic        m_off, m_sleep, m_chip;
  logic [15:0] m_intv;
  int          m_k;
  logic        an_v, link_v, ed_v;

  function automatic logic [1:0] next_mode(input logic off, input logic sl,
                                           input logic an, input logic lk, input logic ed);
    if (m_chip) return 2'd3;
    if (off) return 2'd1;
    if (sl && an && !lk && !ed) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [3:0] exp_en(input logic [1:0] m);
    case (m)
      2'd0: return 4'b1111;
      2'd1: return 4'b0001;
      2'd2: return 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd();
    logic [15:0] v = 16'd0;
    if (m_mode == 2'd3) return v;
    if (!mgmt_ext && mgmt_addr == 8'h00) v[11] = m_off;
    if (mgmt_ext && mgmt_dev == 5'h1C && mgmt_addr == 8'h23) v[0] = m_sleep;
    if (mgmt_ext && mgmt_dev == 5'h1C && mgmt_addr == 8'h24) v = m_intv;
    return v;
  endfunction

  function automatic logic exp_lp();
    int per;
    per = PRESC * ((m_intv == 16'd0) ? 1 : int'(m_intv));
    return (m_mode == 2'd2) && (m_k != 0) && (m_k % per == 0);
  endfunction

  task automatic chk(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [15:0] er;
    logic [3:0]  ee;
    er = exp_rd();
    ee = exp_en(m_mode);
    chk(pwr_mode == m_mode, "mode (R9 priority)", 16'(pwr_mode), 16'(m_mode));
    chk({tx_en, ed_en, rx_en, mgmt_en} == ee, "enables (R3/R5/R8)",
        16'({tx_en, ed_en, rx_en, mgmt_en}), 16'(ee));
    chk(lp_req == exp_lp(), "lp_req (R7)", 16'(lp_req), 16'(exp_lp()));
    chk(mgmt_rdata == er, "rdata", mgmt_rdata, er);
  endtask

  task automatic step(input logic wr, input logic ext, input logic [4:0] dev,
                      input logic [7:0] addr, input logic [15:0] data);
    logic [1:0] nm;
    @(negedge clk);
    check_outputs();
    an_en = an_v; link_up = link_v; energy_det = ed_v;
    mgmt_wr = wr; mgmt_ext = ext; mgmt_dev = dev; mgmt_addr = addr; mgmt_wdata = data;
    nm = next_mode(m_off, m_sleep, an_v, link_v, ed_v);
    if (wr && !m_chip) begin
      if (!ext && addr == 8'h00) m_off = data[11];
      if (ext && dev == 5'h1C && addr == 8'h23) m_sleep = data[0];
      if (ext && dev == 5'h1C && addr == 8'h24) m_intv = data;
    end
    m_k = (nm == 2'd2 && m_mode == 2'd2) ? m_k + 1 : 0;
    m_mode = nm;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, mgmt_ext, mgmt_dev, mgmt_addr, 16'd0);
  endtask

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_mode = s;
    an_v = 1'b0; link_v = 1'b0; ed_v = 1'b0;
    an_en = 1'b0; link_up = 1'b0; energy_det = 1'b0;
    mgmt_wr = 1'b0; mgmt_ext = 1'b0; mgmt_dev = 5'd0; mgmt_addr = 8'h00; mgmt_wdata = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    m_chip = (s == 4'b0111); m_off = 1'b0; m_sleep = 1'b0; m_intv = INTV_DEF; m_k = 0;
    m_mode = m_chip ? 2'd3 : 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    // R1: reset state and register defaults
    tag = "R1";
    do_reset(4'h0);
    step(1'b0, 1'b0, 5'd0, 8'h00, 16'd0);
    step(1'b0, 1'b1, 5'h1C, 8'h23, 16'd0);
    step(1'b0, 1'b1, 5'h1C, 8'h24, 16'd0);
    idle(1);
    chk(mgmt_rdata == INTV_DEF, "interval default", mgmt_rdata, INTV_DEF);

    // R2: off bit set and cleared; other bits ignored
    tag = "R2";
    step(1'b1, 1'b0, 5'd0, 8'h00, 16'h0800);
    idle(3);
    chk(pwr_mode == 2'd1, "soft off entered", 16'(pwr_mode), 16'd1);
    tag = "R3";
    step(1'b0, 1'b1, 5'h1C, 8'h24, 16'd0);
    step(1'b0, 1'b0, 5'd0, 8'h00, 16'd0);
    step(1'b1, 1'b1, 5'h1C, 8'h23, 16'h0001);
    idle(2);
    tag = "R2";
    step(1'b1, 1'b0, 5'd0, 8'h00, 16'hF7FF);
    idle(3);
    chk(pwr_mode == 2'd0, "soft off left", 16'(pwr_mode), 16'd0);
    step(1'b1, 1'b1, 5'h1C, 8'h23, 16'h0000);

    // R10: decoys
    tag = "R10";
    step(1'b1, 1'b1, 5'h1D, 8'h23, 16'hFFFF);
    step(1'b1, 1'b0, 5'd0, 8'h23, 16'hFFFF);
    step(1'b1, 1'b1, 5'h1C, 8'h00, 16'hFFFF);
    step(1'b1, 1'b0, 5'd0, 8'h01, 16'hFFFF);
    step(1'b0, 1'b1, 5'h1C, 8'h23, 16'd0);
    step(1'b0, 1'b0, 5'd0, 8'h00, 16'd0);
    step(1'b0, 1'b1, 5'h1C, 8'h24, 16'd0);
    idle(1);

    // R4 / R7: interval 0 acts as 1
    tag = "R4";
    step(1'b1, 1'b1, 5'h1C, 8'h24, 16'd0);
    an_v = 1'b1;
    step(1'b1, 1'b1, 5'h1C, 8'h23, 16'h0001);
    idle(3);
    chk(pwr_mode == 2'd2, "sleep entered", 16'(pwr_mode), 16'd2);
    tag = "R7";
    idle(20);
    // R6: exits
    tag = "R6";
    ed_v = 1'b1; idle(1); ed_v = 1'b0; idle(3);
    link_v = 1'b1; idle(2); link_v = 1'b0; idle(2);
    an_v = 1'b0; idle(2); an_v = 1'b1; idle(2);
    step(1'b1, 1'b1, 5'h1C, 8'h23, 16'h0000);
    idle(3);
    chk(pwr_mode == 2'd0, "sleep left on enable clear", 16'(pwr_mode), 16'd0);
    // R7: longer interval
    tag = "R7";
    step(1'b1, 1'b1, 5'h1C, 8'h24, 16'd3);
    step(1'b1, 1'b1, 5'h1C, 8'h23, 16'h0001);
    idle(40);
    // R9: off bit overrides sleep
    tag = "R9";
    step(1'b1, 1'b0, 5'd0, 8'h00, 16'h0800);
    idle(4);
    chk(pwr_mode == 2'd1, "soft off over sleep", 16'(pwr_mode), 16'd1);
    step(1'b1, 1'b0, 5'd0, 8'h00, 16'h0000);
    idle(4);

    // random mix
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      int          sel;
      logic        wr, ext;
      logic [4:0]  dev;
      logic [7:0]  addr;
      logic [15:0] data;
      if ($urandom % 50 == 0) an_v = ~an_v;
      if ($urandom % 30 == 0) link_v = ~link_v;
      ed_v = ($urandom % 40 == 0);
      sel  = int'($urandom % 6);
      data = 16'($urandom);
      case (sel)
        0: begin ext = 1'b0; dev = 5'd0;  addr = 8'h00; data[11] = ($urandom % 4 == 0); end
        1: begin ext = 1'b1; dev = 5'h1C; addr = 8'h23; data[0] = ($urandom % 4 != 0); end
        2: begin ext = 1'b0; dev = 5'd0;  addr = 8'h01; end
        3: begin ext = 1'b1; dev = 5'h1D; addr = 8'h23; end
        4: begin ext = 1'b1; dev = 5'h1C; addr = 8'h25; end
        default: begin ext = 1'b1; dev = 5'h1C; addr = 8'h24; end
      endcase
      wr = ($urandom % 8 == 0) && (sel != 5);
      step(wr, ext, dev, addr, data);
    end

    // R8: chip off by strap
    tag = "R8";
    do_reset(4'b0111);
    an_v = 1'b1;
    step(1'b1, 1'b0, 5'd0, 8'h00, 16'h0000);
    step(1'b1, 1'b1, 5'h1C, 8'h23, 16'h0001);
    step(1'b1, 1'b1, 5'h1C, 8'h24, 16'h0009);
    idle(5);
    chk(pwr_mode == 2'd3 && !mgmt_en, "chip off held", 16'({pwr_mode, mgmt_en}), 16'h6);
    do_reset(4'b0110);
    tag = "R1";
    step(1'b0, 1'b1, 5'h1C, 8'h23, 16'd0);
    step(1'b0, 1'b1, 5'h1C, 8'h24, 16'd0);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule